// File: doc/BRIEF.md
# Corrected-Data Output Scheduler

This block decides when a host processor may collect error-corrected blocks from a broadcast data receiver. It counts block positions inside a frame from a block-start strobe. That strobe comes from the sync detector once a block's sync code has been seen. A frame-first qualifier and two lock levels, one for block lock and one for frame lock, complete the input. The data of a block is offered to the host only while the next block is arriving. Each offer opens a read window. The block pulls its ready and interrupt lines low, and it presents one horizontally corrected buffer index and, when vertical output is running, one vertically corrected data-block index.

Vertical output is armed for a frame when the whole previous frame was counted under lock and at least one of its blocks failed horizontal correction. The block then emits one vertical data-block index per received block over a fixed span of positions, counting upward from 1. Parity positions never produce an index. A window shares its time between both kinds of data and uses the short limit. A window with horizontal data only uses the long limit. When a window runs out, the buffer may be overwritten. The block drops its offers, flags data as not guaranteed, and records an overrun if the host was still shifting.

Both offers are valid/ready streams. A valid, once raised, holds its index steady until ready is seen or until the window closes. The window closes either by timeout or by the arrival of the next block. Closing withdraws the offer without a transfer, because the upstream buffer is reused. Ready may stay high at any time. Only one transfer per stream happens per window.

Top module: `corr_out_sched`

## Requirements
- R1: After reset, rdy_n and irq_n are 1, h_valid, v_valid, ng and ovr are 0, and win_mode is 0.
- R2: Position 1 is a locked strobe with frm_first=1, and each later locked strobe adds 1. The cycle after the strobe's clock edge is the strobe cycle. If the block before the strobe had a known position, then from the cycle after the strobe cycle rdy_n and irq_n are 0, h_valid is 1 and h_idx is that earlier position.
- R3: A window carries at most one horizontal and one vertical transfer. A valid falls in the cycle after its handshake. irq_n is 0 exactly while at least one offer is pending, and only while rdy_n is 0.
- R4: rdy_n stays 0 for WIN_H*TICK_DIV cycles when only horizontal data is offered (win_mode=1). It stays 0 for WIN_HV*TICK_DIV cycles when vertical data is offered too (win_mode=2).
- R5: When a window times out, rdy_n returns to 1, both valids fall, and ng is 1 until the next locked strobe.
- R6: If host_busy is 1 when a window closes, ovr becomes 1 and stays 1 until reset.
- R7: Vertical output is armed for a frame only if the previous frame ran from position 1 through FRAME_BLKS under lock and an hfail_stb was seen during it.
- R8: In an armed frame, v_valid is offered only in windows opened at positions V_START to V_START+V_COUNT-1, with v_idx = position - V_START + 1. No other window carries vertical data.
- R9: Dropping either lock clears the position and disarms vertical output. No window opens until a new frm_first strobe has been followed by another strobe.
- R10: A locked strobe that arrives while a window is open closes that window and opens a new one with the new indices and a full-length timer.
- R11: While a valid is high without ready, its index and valid stay unchanged until the window closes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| blk_stb | input | 1 | One-cycle block-start strobe from the sync detector |
| frm_first | input | 1 | Qualifies blk_stb as the first block of a frame |
| blk_lock | input | 1 | Block synchronisation held |
| frm_lock | input | 1 | Frame synchronisation held |
| hfail_stb | input | 1 | A block of this frame failed horizontal correction |
| host_busy | input | 1 | Host serial read in progress |
| h_valid | output | 1 | Horizontal block offer pending |
| h_ready | input | 1 | Host takes the horizontal offer |
| h_idx | output | PW | Buffer position of the horizontal block |
| v_valid | output | 1 | Vertical block offer pending |
| v_ready | input | 1 | Host takes the vertical offer |
| v_idx | output | VW | Vertical data-block number, 1-based |
| rdy_n | output | 1 | Low while a read window is open |
| irq_n | output | 1 | Low while an offer awaits the host |
| win_mode | output | 2 | 0 closed, 1 horizontal only, 2 horizontal and vertical |
| ng | output | 1 | Data not guaranteed since the last timeout |
| ovr | output | 1 | Sticky: a window closed during a host read |

## Verification
The bench runs four small frames back to back, with every block strobed and checked. The frames cover: no previous frame, a clean previous frame, and two frames whose predecessors saw a correction failure. This separates the arming rule from the position span and the index arithmetic. Alternating between accepting at once and never accepting shows the difference between a handshake closing an offer and a timeout withdrawing it. The two window lengths show whether the limit follows the presence of vertical data. A busy host at one timeout, a strobe arriving inside an open window, and a lock drop followed by re-entry check, in turn, the overrun flag, the overwrite-and-restart path and the recovery rule.

// File: rtl/cos_pkg.sv
package cos_pkg;
  typedef enum logic [1:0] {
    MODE_CLOSED = 2'd0,
    MODE_H      = 2'd1,
    MODE_HV     = 2'd2
  } win_mode_e;
endpackage

// File: rtl/cos_blk_track.sv
module cos_blk_track #(
  parameter int FRAME_BLKS = 272,
  parameter int V_START    = 29,
  parameter int V_COUNT    = 190,
  localparam int PW = $clog2(FRAME_BLKS + 1),
  localparam int VW = $clog2(V_COUNT + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          blk_stb,
  input  logic          frm_first,
  input  logic          blk_lock,
  input  logic          frm_lock,
  input  logic          hfail_stb,
  output logic          new_blk,
  output logic [PW-1:0] prev_pos,
  output logic          v_act,
  output logic [VW-1:0] v_idx
);
  localparam logic [PW-1:0] LAST = PW'(FRAME_BLKS);
  localparam logic [PW-1:0] VLO  = PW'(V_START);
  localparam logic [PW-1:0] VHI  = PW'(V_START + V_COUNT - 1);

  logic [PW-1:0] pos_q, prev_q;
  logic          arm_q, fail_q, new_q;
  logic          locked;

  assign locked = blk_lock & frm_lock;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pos_q  <= '0;
      prev_q <= '0;
      arm_q  <= 1'b0;
      fail_q <= 1'b0;
      new_q  <= 1'b0;
    end else begin
      new_q <= blk_stb & locked;
      if (!locked) begin
        pos_q  <= '0;
        prev_q <= '0;
        arm_q  <= 1'b0;
        fail_q <= 1'b0;
      end else if (blk_stb) begin
        prev_q <= pos_q;
        if (frm_first) begin
          pos_q  <= PW'(1);
          arm_q  <= (pos_q == LAST) && fail_q;
          fail_q <= hfail_stb;
        end else if (pos_q != '0 && pos_q < LAST) begin
          pos_q  <= pos_q + PW'(1);
          fail_q <= fail_q | hfail_stb;
        end else begin
          pos_q  <= '0;
          arm_q  <= 1'b0;
          fail_q <= 1'b0;
        end
      end else begin
        fail_q <= fail_q | hfail_stb;
      end
    end
  end

  assign new_blk  = new_q;
  assign prev_pos = prev_q;
  assign v_act    = arm_q && (pos_q >= VLO) && (pos_q <= VHI);
  assign v_idx    = VW'(pos_q - VLO + PW'(1));

  // R9: a lock drop empties the position and disarms vertical output
  assert_unlock_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !locked |=> (pos_q == '0 && !arm_q));
  // R7: arming only ever happens on the first block of a frame
  assert_arm_at_first_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(arm_q) |-> (pos_q == PW'(1) && $past(blk_stb && frm_first)));
  // R8: vertical numbers stay inside the data span
  assert_vidx_span_R8: assert property (@(posedge clk) disable iff (!rst_n)
    v_act |-> (v_idx >= VW'(1) && v_idx <= VW'(V_COUNT)));
endmodule

// File: rtl/cos_win_timer.sv
module cos_win_timer #(
  parameter int TICK_DIV = 250,
  parameter int TW       = 16,
  localparam int DW = $clog2(TICK_DIV + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [TW-1:0] lim,
  output logic          expire
);
  logic [DW-1:0] div_q;
  logic [TW-1:0] tick_q, lim_q;
  logic          run_q;

  assign expire = run_q && (div_q == DW'(TICK_DIV - 1)) && (tick_q == lim_q - TW'(1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      div_q  <= '0;
      tick_q <= '0;
      lim_q  <= '0;
      run_q  <= 1'b0;
    end else if (start) begin
      div_q  <= '0;
      tick_q <= '0;
      lim_q  <= lim;
      run_q  <= 1'b1;
    end else if (run_q) begin
      if (expire) begin
        run_q <= 1'b0;
      end else if (div_q == DW'(TICK_DIV - 1)) begin
        div_q  <= '0;
        tick_q <= tick_q + TW'(1);
      end else begin
        div_q <= div_q + DW'(1);
      end
    end
  end

  // R4: the tick count never passes the latched limit while running
  assert_tick_below_lim_R4: assert property (@(posedge clk) disable iff (!rst_n)
    run_q |-> (tick_q < lim_q));
endmodule

// File: rtl/cos_offer.sv
module cos_offer
  import cos_pkg::*;
#(
  parameter int PW     = 9,
  parameter int VW     = 8,
  parameter int TW     = 16,
  parameter int WIN_H  = 18000,
  parameter int WIN_HV = 9000
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          new_blk,
  input  logic [PW-1:0] prev_pos,
  input  logic          v_act,
  input  logic [VW-1:0] v_idx_in,
  input  logic          expire,
  input  logic          host_busy,
  input  logic          h_ready,
  input  logic          v_ready,
  output logic          start,
  output logic [TW-1:0] lim,
  output logic          h_valid,
  output logic [PW-1:0] h_idx,
  output logic          v_valid,
  output logic [VW-1:0] v_idx,
  output logic          rdy_n,
  output logic          irq_n,
  output logic [1:0]    win_mode,
  output logic          ng,
  output logic          ovr
);
  logic      win_q, hv_q, ng_q, ovr_q, hv_q_valid, vv_q;
  logic      h_on, closing;
  win_mode_e mode;

  assign h_on    = new_blk && (prev_pos != '0);
  assign start   = h_on;
  assign lim     = v_act ? TW'(WIN_HV) : TW'(WIN_H);
  assign closing = win_q && (expire || new_blk);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      win_q      <= 1'b0;
      hv_q       <= 1'b0;
      hv_q_valid <= 1'b0;
      vv_q       <= 1'b0;
      ng_q       <= 1'b0;
      ovr_q      <= 1'b0;
      h_idx      <= '0;
      v_idx      <= '0;
    end else begin
      if (closing && host_busy) ovr_q <= 1'b1;
      if (new_blk) begin
        win_q      <= h_on;
        hv_q       <= h_on && v_act;
        hv_q_valid <= h_on;
        vv_q       <= h_on && v_act;
        h_idx      <= prev_pos;
        v_idx      <= v_idx_in;
        ng_q       <= 1'b0;
      end else if (win_q && expire) begin
        win_q      <= 1'b0;
        hv_q       <= 1'b0;
        hv_q_valid <= 1'b0;
        vv_q       <= 1'b0;
        ng_q       <= 1'b1;
      end else begin
        if (hv_q_valid && h_ready) hv_q_valid <= 1'b0;
        if (vv_q && v_ready)       vv_q       <= 1'b0;
      end
    end
  end

  always_comb begin
    if (!win_q)    mode = MODE_CLOSED;
    else if (hv_q) mode = MODE_HV;
    else           mode = MODE_H;
  end

  assign h_valid  = hv_q_valid;
  assign v_valid  = vv_q;
  assign rdy_n    = ~win_q;
  assign irq_n    = ~(hv_q_valid | vv_q);
  assign win_mode = mode;
  assign ng       = ng_q;
  assign ovr      = ovr_q;

  // R3: an interrupt is only pending inside an open window
  assert_irq_in_window_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_n |-> !rdy_n);
  // R3: a taken offer is not repeated in the same window
  assert_single_take_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (h_valid && h_ready && !new_blk) |=> !h_valid);
  // R11: an unaccepted offer holds its index
  assert_hold_idx_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (h_valid && !h_ready && !new_blk && !expire) |=> (h_valid && $stable(h_idx)));
  // R5: the not-guaranteed flag never overlaps an open window
  assert_ng_closed_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ng |-> rdy_n);
  // R6: overrun is sticky
  assert_ovr_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ovr |=> ovr);
endmodule

// File: rtl/corr_out_sched.sv
module corr_out_sched #(
  parameter int FRAME_BLKS = 272,
  parameter int V_START    = 29,
  parameter int V_COUNT    = 190,
  parameter int TICK_DIV   = 250,
  parameter int WIN_H      = 18000,
  parameter int WIN_HV     = 9000,
  localparam int PW   = $clog2(FRAME_BLKS + 1),
  localparam int VW   = $clog2(V_COUNT + 1),
  localparam int WMAX = (WIN_H > WIN_HV) ? WIN_H : WIN_HV,
  localparam int TW   = $clog2(WMAX + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          blk_stb,
  input  logic          frm_first,
  input  logic          blk_lock,
  input  logic          frm_lock,
  input  logic          hfail_stb,
  input  logic          host_busy,
  output logic          h_valid,
  input  logic          h_ready,
  output logic [PW-1:0] h_idx,
  output logic          v_valid,
  input  logic          v_ready,
  output logic [VW-1:0] v_idx,
  output logic          rdy_n,
  output logic          irq_n,
  output logic [1:0]    win_mode,
  output logic          ng,
  output logic          ovr
);
  logic          new_blk, v_act, start, expire;
  logic [PW-1:0] prev_pos;
  logic [VW-1:0] v_num;
  logic [TW-1:0] lim;

  cos_blk_track #(
    .FRAME_BLKS(FRAME_BLKS), .V_START(V_START), .V_COUNT(V_COUNT)
  ) u_track (
    .clk(clk), .rst_n(rst_n), .blk_stb(blk_stb), .frm_first(frm_first),
    .blk_lock(blk_lock), .frm_lock(frm_lock), .hfail_stb(hfail_stb),
    .new_blk(new_blk), .prev_pos(prev_pos), .v_act(v_act), .v_idx(v_num)
  );

  cos_win_timer #(.TICK_DIV(TICK_DIV), .TW(TW)) u_timer (
    .clk(clk), .rst_n(rst_n), .start(start), .lim(lim), .expire(expire)
  );

  cos_offer #(
    .PW(PW), .VW(VW), .TW(TW), .WIN_H(WIN_H), .WIN_HV(WIN_HV)
  ) u_offer (
    .clk(clk), .rst_n(rst_n), .new_blk(new_blk), .prev_pos(prev_pos),
    .v_act(v_act), .v_idx_in(v_num), .expire(expire), .host_busy(host_busy),
    .h_ready(h_ready), .v_ready(v_ready), .start(start), .lim(lim),
    .h_valid(h_valid), .h_idx(h_idx), .v_valid(v_valid), .v_idx(v_idx),
    .rdy_n(rdy_n), .irq_n(irq_n), .win_mode(win_mode), .ng(ng), .ovr(ovr)
  );
endmodule

// File: tb/corr_out_sched_tb.sv
module corr_out_sched_tb;
  localparam int F   = 12;
  localparam int VS  = 3;
  localparam int VC  = 6;
  localparam int D   = 2;
  localparam int WH  = 6;
  localparam int WHV = 3;

  logic clk = 0, rst_n = 0;
  logic blk_stb = 0, frm_first = 0, blk_lock = 0, frm_lock = 0, hfail_stb = 0;
  logic host_busy = 0, h_ready = 0, v_ready = 0;
  logic h_valid, v_valid, rdy_n, irq_n, ng, ovr;
  logic [3:0] h_idx;
  logic [2:0] v_idx;
  logic [1:0] win_mode;

  int total = 0, bad = 0;
  int mpos = 0, mprev = 0, last_n = 0, last_exp = 0;
  bit marm = 0, mfail = 0, movr = 0;

  always #2 clk = ~clk;

  corr_out_sched #(.FRAME_BLKS(F), .V_START(VS), .V_COUNT(VC), .TICK_DIV(D),
                   .WIN_H(WH), .WIN_HV(WHV)) u_dut (
    .clk(clk), .rst_n(rst_n), .blk_stb(blk_stb), .frm_first(frm_first),
    .blk_lock(blk_lock), .frm_lock(frm_lock), .hfail_stb(hfail_stb),
    .host_busy(host_busy), .h_valid(h_valid), .h_ready(h_ready), .h_idx(h_idx),
    .v_valid(v_valid), .v_ready(v_ready), .v_idx(v_idx), .rdy_n(rdy_n),
    .irq_n(irq_n), .win_mode(win_mode), .ng(ng), .ovr(ovr));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic strobe(input bit first, input bit fail);
    @(negedge clk);
    blk_stb = 1; frm_first = first; hfail_stb = fail;
    mprev = mpos;
    if (first) begin
      marm = (mpos == F) && mfail; mfail = fail; mpos = 1;
    end else if (mpos != 0 && mpos < F) begin
      mpos++; mfail = mfail | fail;
    end else begin
      mpos = 0; marm = 0; mfail = 0;
    end
    @(negedge clk);
    blk_stb = 0; frm_first = 0; hfail_stb = 0;
  endtask

  task automatic check_win(input bit acc, input bit busy);
    bit ev;
    int n;
    host_busy = busy;
    @(negedge clk);
    if (mprev == 0) begin
      host_busy = 0;
      for (int k = 0; k < 3; k++) begin
        chk(rdy_n && !h_valid && !v_valid, "R9 no window", rdy_n, 1);
        @(negedge clk);
      end
      return;
    end
    ev = marm && mpos >= VS && mpos <= VS + VC - 1;
    last_exp = (ev ? WHV : WH) * D;
    chk(!rdy_n && !irq_n, "R2 lines low", {rdy_n, irq_n}, 0);
    chk(h_valid && h_idx == mprev, "R2 h_idx", h_idx, mprev);
    chk(v_valid == ev, "R7 R8 v_valid", v_valid, ev);
    if (ev) chk(v_idx == mpos - VS + 1, "R8 v_idx", v_idx, mpos - VS + 1);
    chk(win_mode == (ev ? 2 : 1), "R4 mode", win_mode, ev ? 2 : 1);
    n = 0;
    while (!rdy_n && n < 200) begin
      n++;
      if (acc && n == 1) begin h_ready = 1; v_ready = 1; end
      if (acc && n == 2) begin
        h_ready = 0; v_ready = 0;
        chk(!h_valid && !v_valid && irq_n && !rdy_n, "R3 taken", {h_valid, v_valid, irq_n}, 1);
      end
      if (!acc && n == 3)
        chk(h_valid && h_idx == mprev && v_valid == ev && !irq_n, "R11 hold", h_idx, mprev);
      @(negedge clk);
    end
    last_n = n;
    chk(n == last_exp, "R4 length", n, last_exp);
    chk(ng && !h_valid && !v_valid && irq_n, "R5 timeout", ng, 1);
    host_busy = 0;
    if (busy) movr = 1;
    chk(ovr == movr, "R6 ovr", ovr, movr);
    repeat (2) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog actual=0 expected=1");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(rdy_n && irq_n && !h_valid && !v_valid, "R1 lines", {rdy_n, irq_n}, 3);
    chk(!ng && !ovr && win_mode == 0, "R1 flags", {ng, ovr, win_mode}, 0);
    rst_n = 1; blk_lock = 1; frm_lock = 1;
    @(negedge clk);
    for (int f = 0; f < 4; f++)
      for (int b = 1; b <= F; b++) begin
        strobe(b == 1, (f == 1 && b == 4) || (f == 2 && b == 2));
        check_win(b % 2 == 0, f == 2 && b == 9);
      end
    // R10: a strobe inside an open window restarts it
    strobe(1, 0);
    repeat (3) @(negedge clk);
    chk(!rdy_n && h_idx == F, "R10 first window", h_idx, F);
    strobe(0, 0);
    check_win(0, 0);
    chk(last_n == last_exp && h_idx == 1, "R10 restart", last_n, last_exp);
    // R9: lock loss
    @(negedge clk); frm_lock = 0;
    @(negedge clk); @(negedge clk); frm_lock = 1; mpos = 0; mprev = 0; marm = 0; mfail = 0;
    strobe(0, 1);
    check_win(1, 0);
    strobe(1, 0);
    check_win(1, 0);
    for (int b = 2; b <= VS + 1; b++) begin
      strobe(0, 0);
      check_win(1, 0);
    end
    chk(ovr == 1, "R6 sticky", ovr, 1);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule